// File: doc/BRIEF.md
# Debug Breakpoint Address Comparator

This block watches every access on a CPU bus and raises a one-clock match flag when the access hits a programmed breakpoint. It has two comparators, A and B. Each holds a breakpoint page, a high address byte, a low address byte and a control byte.

A 16 KiB paged program window sits at bus addresses with bits [15:14] equal to 2'b10. An access inside that window is compared as a 20-bit paged address: the 6-bit page input is checked against the stored page, and bus address bits [13:0] are checked against the low six bits of the high register followed by the low register. Any other access is compared as a plain 16-bit address against the full high and low registers.

Two byte-mask bits widen a breakpoint into a 256-byte or 16 KiB region. An optional qualifier restricts a comparator to reads or to writes. A mode bit turns comparator B into a data comparator. In that mode B fires when comparator A's address and direction match and the bus data matches B's data registers under B's byte masks.

Software writes the configuration one byte at a time through a small register port with a synchronous write enable. The match flags are registered, so each flag reflects the bus access that was sampled on the previous clock edge.

Top module: `bkpt_cmp_top`

## Requirements
- R1: After reset every configuration register reads as zero, so both comparators are disabled, full mode is off, and neither hit output is asserted for any access.
- R2: A hit output goes high in the clock cycle after an edge where `bus_valid` was high and the access matched. It is low in the cycle after any edge where `bus_valid` was low.
- R3: For an access outside the paged window, a full compare requires `bus_addr` to equal {high register, low register}. The page input is ignored in this case.
- R4: For an access inside the window (`bus_addr[15:14]` = 2'b10), a full compare requires three things: `bus_page` equals the stored page, `bus_addr[13:8]` equals bits [5:0] of the high register, and `bus_addr[7:0]` equals the low register. Bits [7:6] of the high register are ignored.
- R5: Mask code 0:1 (control bit 4 = 0, control bit 3 = 1) drops the low-byte compare. The result is a match anywhere in a 256-byte block, with the page still checked for paged accesses.
- R6: Mask code 1:1 (control bits 4 and 3 both set) compares the page field only. It matches any paged access whose page equals the stored page, and it never matches an access outside the window.
- R7: Mask code 1:0 (control bit 4 = 1, control bit 3 = 0) behaves exactly like a full compare. The high-mask bit has no effect in this case.
- R8: When the direction-enable bit (control bit 1) is 0, `bus_rnw` is ignored. When it is 1, the comparator matches only when `bus_rnw` equals the direction bit (control bit 2): 0 selects writes and 1 selects reads.
- R9: A comparator whose enable bit (control bit 0) is 0 never asserts its hit output.
- R10: With full mode on (bit 0 of offset 8), `hit_b` requires three things: comparator B is enabled, comparator A's address and direction match, and the data matches. The data match compares `bus_data[15:8]` with B's high register and `bus_data[7:0]` with B's low register, where B's control bit 4 masks the high byte and bit 3 masks the low byte (code 1:0 is honoured for data). B's direction bits are ignored in this mode, and A's enable bit does not gate `hit_b`.
- R11: The write port uses byte offsets 0–3 for comparator A (page, high, low, control) and 4–7 for comparator B in the same order, with the mode bit at offset 8. A write takes effect on the clock edge where `cfg_we` is high. Values presented while `cfg_we` is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_addr | input | 16 | CPU logical address |
| bus_page | input | 6 | Current program page |
| bus_data | input | 16 | Bus data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| hit_a | output | 1 | Comparator A match pulse |
| hit_b | output | 1 | Comparator B match pulse |

## Verification
The assertions check the following on every cycle:
- every hit traces back to a valid bus access in the previous cycle;
- every hit traces back to an enabled comparator;
- every hit honours the direction qualifier;
- a page-only breakpoint matches only inside the window;
- an unmasked hit outside the window carries exactly the stored 16-bit address.

Other behaviours need the bench's scenarios. These include the 256-byte range boundary, the forced handling of mask code 1:0, and the ignored upper high-register bits in paged compares. They also include the full-mode data match with its byte masks and the interaction between the two comparators, as well as proof that writes with the enable low leave the configuration untouched.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int PAGE_W  = 6;
    localparam int WIN_W   = 2;
    localparam logic [WIN_W-1:0] WIN_CODE = 2'b10;
    localparam int NCMP    = 2;
    localparam int CFG_AW  = 4;
    localparam int REGS_PER_CMP = 4;

    // per-comparator register offsets inside its group
    localparam int OFS_PAGE = 0;
    localparam int OFS_HI   = 1;
    localparam int OFS_LO   = 2;
    localparam int OFS_CTRL = 3;
    localparam int OFS_MODE = NCMP * REGS_PER_CMP;

    // control byte bit positions
    localparam int CB_EN     = 0;
    localparam int CB_RW_EN  = 1;
    localparam int CB_RW_DIR = 2;
    localparam int CB_MASK_L = 3;
    localparam int CB_MASK_H = 4;

    typedef struct packed {
        logic              en;
        logic              rw_en;
        logic              rw_dir;
        logic              mask_hi;
        logic              mask_lo;
        logic [PAGE_W-1:0] page;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cmp_cfg_t;

    typedef struct packed {
        cmp_cfg_t [NCMP-1:0] cmp;
        logic                full_mode;
    } cfg_t;

    typedef struct packed {
        logic a;
        logic b;
    } hit_t;
endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int i = 0; i < NCMP; i++) begin
                if (waddr == AW'(i * REGS_PER_CMP + OFS_PAGE))
                    cfg_d.cmp[i].page = wdata[PAGE_W-1:0];
                if (waddr == AW'(i * REGS_PER_CMP + OFS_HI))
                    cfg_d.cmp[i].hi = wdata;
                if (waddr == AW'(i * REGS_PER_CMP + OFS_LO))
                    cfg_d.cmp[i].lo = wdata;
                if (waddr == AW'(i * REGS_PER_CMP + OFS_CTRL)) begin
                    cfg_d.cmp[i].en      = wdata[CB_EN];
                    cfg_d.cmp[i].rw_en   = wdata[CB_RW_EN];
                    cfg_d.cmp[i].rw_dir  = wdata[CB_RW_DIR];
                    cfg_d.cmp[i].mask_lo = wdata[CB_MASK_L];
                    cfg_d.cmp[i].mask_hi = wdata[CB_MASK_H];
                end
            end
            if (waddr == AW'(OFS_MODE))
                cfg_d.full_mode = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bkpt_addr_match.sv
module bkpt_addr_match
    import bkpt_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int BW  = BYTE_W,
    parameter int PW  = PAGE_W,
    parameter int WW  = WIN_W,
    parameter logic [WW-1:0] WCODE = WIN_CODE
) (
    input  logic [AW-1:0] bus_addr,
    input  logic [PW-1:0] bus_page,
    input  logic          bus_rnw,
    input  logic [PW-1:0] cfg_page,
    input  logic [BW-1:0] cfg_hi,
    input  logic [BW-1:0] cfg_lo,
    input  logic          mask_hi,
    input  logic          mask_lo,
    input  logic          rw_en,
    input  logic          rw_dir,
    output logic          addr_hit,
    output logic          rw_ok
);
    localparam int OFF_HI_W = AW - WW - BW;

    logic paged, page_eq, hi_eq, lo_eq, eff_mask_hi, range_ok;

    always_comb begin
        paged   = (bus_addr[AW-1 -: WW] == WCODE);
        page_eq = (bus_page == cfg_page);
        if (paged)
            hi_eq = (bus_addr[AW-WW-1:BW] == cfg_hi[OFF_HI_W-1:0]);
        else
            hi_eq = (bus_addr[AW-1:BW] == cfg_hi);
        lo_eq       = (bus_addr[BW-1:0] == cfg_lo);
        // high-only masking is meaningless; only honour it with low mask
        eff_mask_hi = mask_hi & mask_lo;
        range_ok    = paged ? page_eq : ~eff_mask_hi;
        addr_hit    = range_ok & (eff_mask_hi | hi_eq) & (mask_lo | lo_eq);
        rw_ok       = ~rw_en | (bus_rnw == rw_dir);
    end
endmodule

// File: rtl/bkpt_data_match.sv
module bkpt_data_match
    import bkpt_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic [2*BW-1:0] bus_data,
    input  logic [BW-1:0]   cfg_hi,
    input  logic [BW-1:0]   cfg_lo,
    input  logic            mask_hi,
    input  logic            mask_lo,
    output logic            data_hit
);
    logic hi_eq, lo_eq;

    always_comb begin
        hi_eq    = (bus_data[2*BW-1:BW] == cfg_hi);
        lo_eq    = (bus_data[BW-1:0] == cfg_lo);
        data_hit = (mask_hi | hi_eq) & (mask_lo | lo_eq);
    end
endmodule

// File: rtl/bkpt_cmp_top.sv
module bkpt_cmp_top
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    output logic              hit_a,
    output logic              hit_b
);
    cfg_t            cfg_q;
    logic [NCMP-1:0] am_hit;
    logic [NCMP-1:0] am_rw_ok;
    logic            dm_hit;
    hit_t            hit_d, hit_q;

    bkpt_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        bkpt_addr_match u_am (
            .bus_addr (bus_addr),
            .bus_page (bus_page),
            .bus_rnw  (bus_rnw),
            .cfg_page (cfg_q.cmp[i].page),
            .cfg_hi   (cfg_q.cmp[i].hi),
            .cfg_lo   (cfg_q.cmp[i].lo),
            .mask_hi  (cfg_q.cmp[i].mask_hi),
            .mask_lo  (cfg_q.cmp[i].mask_lo),
            .rw_en    (cfg_q.cmp[i].rw_en),
            .rw_dir   (cfg_q.cmp[i].rw_dir),
            .addr_hit (am_hit[i]),
            .rw_ok    (am_rw_ok[i])
        );
    end

    bkpt_data_match u_dm (
        .bus_data (bus_data),
        .cfg_hi   (cfg_q.cmp[1].hi),
        .cfg_lo   (cfg_q.cmp[1].lo),
        .mask_hi  (cfg_q.cmp[1].mask_hi),
        .mask_lo  (cfg_q.cmp[1].mask_lo),
        .data_hit (dm_hit)
    );

    always_comb begin
        hit_d   = '0;
        hit_d.a = bus_valid & cfg_q.cmp[0].en & am_hit[0] & am_rw_ok[0];
        if (cfg_q.full_mode)
            hit_d.b = bus_valid & cfg_q.cmp[1].en & am_hit[0] & am_rw_ok[0] & dm_hit;
        else
            hit_d.b = bus_valid & cfg_q.cmp[1].en & am_hit[1] & am_rw_ok[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit_d;
    end

    assign hit_a = hit_q.a;
    assign hit_b = hit_q.b;
endmodule

// File: rtl/bkpt_cmp_chk.sv
module bkpt_cmp_chk
    import bkpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rnw,
    input cfg_t              cfg,
    input logic              hit_a,
    input logic              hit_b
);
    AST_HIT_A_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |-> $past(bus_valid)); // R2
    AST_HIT_B_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |-> $past(bus_valid)); // R2
    AST_HIT_A_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |-> $past(cfg.cmp[0].en)); // R9
    AST_HIT_B_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |-> $past(cfg.cmp[1].en)); // R9
    AST_RW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && $past(cfg.cmp[0].rw_en)) |-> ($past(bus_rnw) == $past(cfg.cmp[0].rw_dir))); // R8
    AST_PAGE_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && $past(cfg.cmp[0].mask_hi && cfg.cmp[0].mask_lo))
        |-> ($past(bus_addr[ADDR_W-1 -: WIN_W]) == WIN_CODE)); // R6
    AST_FULL_UNPAGED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !$past(cfg.cmp[0].mask_lo) && ($past(bus_addr[ADDR_W-1 -: WIN_W]) != WIN_CODE))
        |-> ($past(bus_addr) == {$past(cfg.cmp[0].hi), $past(cfg.cmp[0].lo)})); // R3
endmodule

bind bkpt_cmp_top bkpt_cmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_rnw   (bus_rnw),
    .cfg       (cfg_q),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
);

// File: tb/bkpt_cmp_top_bench.sv
`timescale 1ns/1ps
module bkpt_cmp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [5:0]  bus_page = '0;
    logic [15:0] bus_data = '0;
    logic        bus_rnw = 1'b0;
    logic        hit_a, hit_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] sh [0:8];

    always #2.5 clk = ~clk;

    bkpt_cmp_top u_bkpt_cmp_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_page(bus_page), .bus_data(bus_data), .bus_rnw(bus_rnw),
        .hit_a(hit_a), .hit_b(hit_b)
    );

    // address + direction match of the comparator whose registers start at base
    function automatic logic amatch(int base, logic [15:0] a, logic [5:0] p, logic rnw);
        logic [7:0] c;
        logic in_win, ok;
        c      = sh[base+3];
        in_win = (a[15:14] == 2'b10);
        if (c[4] && c[3])
            ok = in_win && (p == sh[base][5:0]);
        else if (c[3])
            ok = in_win ? (p == sh[base][5:0] && a[13:8] == sh[base+1][5:0])
                        : (a[15:8] == sh[base+1]);
        else
            ok = in_win ? (p == sh[base][5:0] && a[13:0] == {sh[base+1][5:0], sh[base+2]})
                        : (a == {sh[base+1], sh[base+2]});
        if (c[1] && (rnw != c[2])) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic exp_a(logic v, logic [15:0] a, logic [5:0] p, logic rnw);
        return v && sh[3][0] && amatch(0, a, p, rnw);
    endfunction

    function automatic logic exp_b(logic v, logic [15:0] a, logic [5:0] p, logic [15:0] d, logic rnw);
        logic dm;
        dm = (sh[7][4] || d[15:8] == sh[5]) && (sh[7][3] || d[7:0] == sh[6]);
        if (!v || !sh[7][0]) return 1'b0;
        if (sh[8][0]) return amatch(0, a, p, rnw) && dm;
        return amatch(4, a, p, rnw);
    endfunction

    task automatic wr(int ofs, logic [7:0] val);
        @(negedge clk);
        bus_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 4'(ofs);
        cfg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        sh[ofs] = (ofs == 8) ? {7'd0, val[0]} : val;
    endtask

    task automatic vec(string tag, logic v, logic [15:0] a, logic [5:0] p,
                       logic [15:0] d, logic rnw);
        logic ea, eb;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_page = p; bus_data = d; bus_rnw = rnw;
        ea = exp_a(v, a, p, rnw);
        eb = exp_b(v, a, p, d, rnw);
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (hit_a !== ea || hit_b !== eb) begin
            n_bad++;
            $display("FAIL %s addr=%h page=%h data=%h rnw=%b: hit_a=%b hit_b=%b expected %b %b",
                     tag, a, p, d, rnw, hit_a, hit_b, ea, eb);
        end
        bus_valid = 1'b0;
    endtask

    task automatic expect_hits(string tag, logic [15:0] a, logic [5:0] p, logic [15:0] d,
                               logic rnw, logic want_a, logic want_b);
        logic ga, gb;
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_page = p; bus_data = d; bus_rnw = rnw;
        @(posedge clk);
        @(negedge clk);
        ga = hit_a; gb = hit_b;
        bus_valid = 1'b0;
        n_chk++;
        if (ga !== want_a || gb !== want_b) begin
            n_bad++;
            $display("FAIL %s addr=%h: hit_a=%b hit_b=%b expected %b %b",
                     tag, a, ga, gb, want_a, want_b);
        end
    endtask

    initial begin
        #(5ns * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < 9; i++) sh[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset leaves both comparators off
        expect_hits("R1", 16'h0000, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0);
        expect_hits("R1", 16'h8000, 6'h00, 16'h0000, 1'b1, 1'b0, 1'b0);

        // R3 / R2: full unpaged compare
        wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h01);
        expect_hits("R3", 16'h1234, 6'h3f, 16'h0, 1'b0, 1'b1, 1'b0);
        expect_hits("R3", 16'h1235, 6'h00, 16'h0, 1'b0, 1'b0, 1'b0);
        vec("R2", 1'b0, 16'h1234, 6'h00, 16'h0, 1'b0);

        // R4: paged 20-bit compare, high reg bits [7:6] ignored
        wr(0, 8'h05); wr(1, 8'hE3); wr(2, 8'h45);
        expect_hits("R4", 16'hA345, 6'h05, 16'h0, 1'b1, 1'b1, 1'b0);
        expect_hits("R4", 16'hA345, 6'h06, 16'h0, 1'b1, 1'b0, 1'b0);
        expect_hits("R4", 16'hA346, 6'h05, 16'h0, 1'b1, 1'b0, 1'b0);

        // R5: 256-byte region
        wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h09);
        expect_hits("R5", 16'h12FF, 6'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        expect_hits("R5", 16'h1300, 6'h00, 16'h0, 1'b0, 1'b0, 1'b0);

        // R6: page-only
        wr(3, 8'h19);
        expect_hits("R6", 16'h8000, 6'h05, 16'h0, 1'b0, 1'b1, 1'b0);
        expect_hits("R6", 16'hBFFF, 6'h04, 16'h0, 1'b0, 1'b0, 1'b0);
        expect_hits("R6", 16'h1234, 6'h05, 16'h0, 1'b0, 1'b0, 1'b0);

        // R7: high-only mask forced to full compare
        wr(3, 8'h11);
        expect_hits("R7", 16'h1234, 6'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        expect_hits("R7", 16'h5634, 6'h00, 16'h0, 1'b0, 1'b0, 1'b0);

        // R8: direction qualifier
        wr(3, 8'h03);
        expect_hits("R8", 16'h1234, 6'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        expect_hits("R8", 16'h1234, 6'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        wr(3, 8'h07);
        expect_hits("R8", 16'h1234, 6'h00, 16'h0, 1'b1, 1'b1, 1'b0);

        // R9: disabled comparator is silent
        wr(3, 8'h00);
        expect_hits("R9", 16'h1234, 6'h00, 16'h0, 1'b1, 1'b0, 1'b0);

        // R11: write without enable changes nothing
        wr(3, 8'h01);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 4'd3; cfg_wdata = 8'h00;
        @(posedge clk);
        expect_hits("R11", 16'h1234, 6'h00, 16'h0, 1'b1, 1'b1, 1'b0);

        // R10: full mode data comparator, B direction bits ignored
        wr(5, 8'hAB); wr(6, 8'hCD); wr(7, 8'h03); wr(8, 8'h01);
        expect_hits("R10", 16'h1234, 6'h00, 16'hABCD, 1'b1, 1'b1, 1'b1);
        expect_hits("R10", 16'h1234, 6'h00, 16'hABCE, 1'b1, 1'b1, 1'b0);
        expect_hits("R10", 16'h1233, 6'h00, 16'hABCD, 1'b1, 1'b0, 1'b0);
        wr(7, 8'h11);
        expect_hits("R10", 16'h1234, 6'h00, 16'h00CD, 1'b0, 1'b1, 1'b1);
        wr(3, 8'h00);
        expect_hits("R10", 16'h1234, 6'h00, 16'h00CD, 1'b0, 1'b0, 1'b1);

        // constrained random
        for (int it = 0; it < 3000; it++) begin
            logic [15:0] a, d;
            logic [5:0]  p;
            int          sel, base;
            if (it % 40 == 0) begin
                for (int r = 0; r < 8; r++) wr(r, 8'($urandom));
                wr(3, 8'($urandom) | 8'h01);
                wr(8, 8'(($urandom % 4) == 0));
            end
            sel  = int'($urandom % 4);
            base = ($urandom % 2 == 0) ? 0 : 4;
            a = 16'($urandom);
            p = 6'($urandom);
            d = 16'($urandom);
            if (sel == 1) a = {sh[base+1], sh[base+2]};
            if (sel == 2) begin
                a = {2'b10, sh[base+1][5:0], sh[base+2]};
                p = sh[base][5:0];
            end
            if (sel != 0 && ($urandom % 3 == 0)) a[3:0] = 4'($urandom);
            if ($urandom % 2 == 0) d = {sh[5], sh[6]};
            vec("R2", ($urandom % 8) != 0, a, p, d, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule